// File: doc/BRIEF.md
# Memory PHY Reset Sequencer

This block produces the reset outputs for a memory PHY. It takes two active-low asynchronous reset inputs and a PLL-lock indication. The global reset covers everything, including the PLL. The soft reset clears only the PHY clock domain and leaves the PLL running. A falling edge on the soft reset also starts a fixed-length reset pulse for the PLL reconfiguration logic. Every reset output asserts at once, without waiting for a clock, and releases on an edge of its own clock.

Release of the PHY domain waits for the PLL. The PHY reset stays high until lock has been seen for a set number of consecutive PHY clock cycles. It returns immediately if lock is lost. A separate active-low request output follows PLL lock directly. A system reset manager that uses this output should act on its falling edge, because the output is low for the whole time the PLL is acquiring lock.

All outputs are active high except `rst_req_n`.

Top module: `phy_rst_ctrl`

## Requirements
- R1: While `glob_rst_n` is low, `pll_rst`, `phy_rst` and `reconf_rst` are all 1, with no clock edge needed.
- R2: After `glob_rst_n` rises, `pll_rst` is still 1 after the first rising `ref_clk` edge and is 0 after the second.
- R3: Pulling `soft_rst_n` low sets `phy_rst` to 1 at once, and `pll_rst` stays 0 for as long as `soft_rst_n` is low.
- R4: A falling edge on `soft_rst_n` makes `reconf_rst` 1 for exactly 4 `ref_clk` cycles. It goes high at the third rising `ref_clk` edge after the fall.
- R5: Holding `soft_rst_n` low after the pulse, and raising it again, causes no further `reconf_rst` pulse.
- R6: Once `glob_rst_n`, `soft_rst_n` and `pll_locked` are all high, `phy_rst` is still 1 after the fourth rising `phy_clk` edge and is 0 after the fifth. This covers two synchronizer stages and two cycles of lock qualification.
- R7: While `pll_locked` is low, `phy_rst` stays 1 even with both reset inputs high.
- R8: When `pll_locked` falls while the PHY domain is running, `phy_rst` becomes 1 at once, with no clock edge needed.
- R9: `rst_req_n` equals `pll_locked` at all times.
- R10: If `soft_rst_n` is already low when `glob_rst_n` is released, no `reconf_rst` pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; drives the PLL and reconfiguration reset logic |
| phy_clk | input | 1 | PHY domain clock |
| glob_rst_n | input | 1 | Global asynchronous reset, active low |
| soft_rst_n | input | 1 | Soft asynchronous reset, active low; spares the PLL |
| pll_locked | input | 1 | PLL lock indication, 1 when locked |
| pll_rst | output | 1 | PLL reset, active high |
| phy_rst | output | 1 | PHY domain reset, active high |
| reconf_rst | output | 1 | PLL reconfiguration reset, active high |
| rst_req_n | output | 1 | Reset request, low while the PLL is unlocked |

## Verification
The hardest case to reach from the ports is a loss of lock while the PHY domain is already running. The bench reaches it by first walking the full release sequence to completion. It then drops `pll_locked` between clock edges and checks `phy_rst` before any edge arrives. The edge-versus-level behaviour of the reconfiguration pulse is reached in two ways: by holding the soft reset low well past the pulse, and by releasing the global reset while the soft reset is already low.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned LOCK_CYCLES_DEF = 2;
  localparam int unsigned PULSE_LEN_DEF   = 4;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or posedge arst) begin
          if (arst) chain[0] <= 1'b0;
          else      chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge arst) begin
          if (arst) chain[i] <= 1'b0;
          else      chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstc_pulse.sv
module rstc_pulse #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk,
  input  logic arst,
  input  logic lvl,
  output logic pulse
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LEN_VAL = PW'(PULSE_LEN);

  logic          prev;
  logic [PW-1:0] cnt;
  logic          fall;

  assign fall = prev & ~lvl;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      prev <= 1'b0;
      cnt  <= '0;
    end else begin
      prev <= lvl;
      if (fall)           cnt <= LEN_VAL;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign pulse = (cnt != '0);

  AST_PULSE_START: assert property (@(posedge clk) disable iff (arst)
    fall |=> pulse); // R4

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (arst)
    (!lvl && !prev && !pulse) |=> !pulse); // R5
endmodule

// File: rtl/rstc_release.sv
module rstc_release #(
  parameter int unsigned LOCK_CYCLES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic ready,
  output logic rst_out
);
  localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LOCK_VAL = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt;
  logic          rst_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      cnt   <= '0;
      rst_q <= 1'b1;
    end else begin
      if (ready && cnt != LOCK_VAL) cnt <= cnt + 1'b1;
      rst_q <= (cnt != LOCK_VAL);
    end
  end

  assign rst_out = rst_q;

  AST_RELEASE_QUALIFIED: assert property (@(posedge clk) disable iff (arst)
    $fell(rst_q) |-> (cnt == LOCK_VAL && ready)); // R6
endmodule

// File: rtl/phy_rst_ctrl.sv
module phy_rst_ctrl
  import rstc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned LOCK_CYCLES = LOCK_CYCLES_DEF,
  parameter int unsigned PULSE_LEN   = PULSE_LEN_DEF
) (
  input  logic ref_clk,
  input  logic phy_clk,
  input  logic glob_rst_n,
  input  logic soft_rst_n,
  input  logic pll_locked,
  output logic pll_rst,
  output logic phy_rst,
  output logic reconf_rst,
  output logic rst_req_n
);
  logic ref_arst;
  logic phy_arst;
  logic glob_ok_ref;
  logic soft_ref;
  logic reconf_pulse;
  logic phy_ready;

  assign ref_arst = ~glob_rst_n;
  assign phy_arst = ~(glob_rst_n & soft_rst_n & pll_locked);

  rstc_sync #(.STAGES(SYNC_STAGES)) u_glob_sync (
    .clk(ref_clk), .arst(ref_arst), .d(1'b1), .q(glob_ok_ref)
  );

  rstc_sync #(.STAGES(SYNC_STAGES)) u_soft_sync (
    .clk(ref_clk), .arst(ref_arst), .d(soft_rst_n), .q(soft_ref)
  );

  assign pll_rst = ~glob_ok_ref;

  rstc_pulse #(.PULSE_LEN(PULSE_LEN)) u_reconf (
    .clk(ref_clk), .arst(pll_rst), .lvl(soft_ref), .pulse(reconf_pulse)
  );

  assign reconf_rst = reconf_pulse | pll_rst;

  rstc_sync #(.STAGES(SYNC_STAGES)) u_phy_sync (
    .clk(phy_clk), .arst(phy_arst), .d(1'b1), .q(phy_ready)
  );

  rstc_release #(.LOCK_CYCLES(LOCK_CYCLES)) u_release (
    .clk(phy_clk), .arst(phy_arst), .ready(phy_ready), .rst_out(phy_rst)
  );

  assign rst_req_n = pll_locked;

  AST_GLOBAL_HOLD: assert property (@(posedge ref_clk) disable iff (1'b0)
    !glob_rst_n |-> (pll_rst && phy_rst && reconf_rst)); // R1

  AST_SOFT_SPARES_PLL: assert property (@(posedge ref_clk) disable iff (!glob_rst_n)
    (!soft_rst_n && !pll_rst) |=> !pll_rst); // R3

  AST_LOCK_DROP: assert property (@(posedge phy_clk) disable iff (!glob_rst_n)
    !pll_locked |-> phy_rst); // R8

  AST_REQ_FOLLOWS_LOCK: assert property (@(posedge ref_clk) disable iff (!glob_rst_n)
    rst_req_n == pll_locked); // R9
endmodule

// File: tb/phy_rst_ctrl_bench.sv
`timescale 1ns/100ps
module phy_rst_ctrl_bench;
  logic ref_clk = 1'b0;
  logic phy_clk = 1'b0;
  logic glob_rst_n, soft_rst_n, pll_locked;
  logic pll_rst, phy_rst, reconf_rst, rst_req_n;
  int checks = 0;
  int errors = 0;

  always #5 ref_clk = ~ref_clk;
  initial begin
    #2.5;
    forever #5 phy_clk = ~phy_clk;
  end

  phy_rst_ctrl u_phy_rst_ctrl (
    .ref_clk(ref_clk), .phy_clk(phy_clk), .glob_rst_n(glob_rst_n),
    .soft_rst_n(soft_rst_n), .pll_locked(pll_locked), .pll_rst(pll_rst),
    .phy_rst(phy_rst), .reconf_rst(reconf_rst), .rst_req_n(rst_req_n)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic ref_tick();
    @(posedge ref_clk); #1;
  endtask

  task automatic phy_tick();
    @(posedge phy_clk); #1;
  endtask

  task automatic release_all();
    glob_rst_n = 1'b1; soft_rst_n = 1'b1; pll_locked = 1'b1;
    repeat (12) phy_tick();
  endtask

  // {glob_rst_n, soft_rst_n, pll_locked}; each has at least one input low
  localparam logic [2:0] VEC [7] = '{3'b000, 3'b001, 3'b010, 3'b011,
                                     3'b100, 3'b101, 3'b110};

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    glob_rst_n = 1'b0; soft_rst_n = 1'b1; pll_locked = 1'b0;
    #1;
    check(pll_rst, 1'b1, "R1 pll_rst at reset");
    check(phy_rst, 1'b1, "R1 phy_rst at reset");
    check(reconf_rst, 1'b1, "R1 reconf_rst at reset");
    check(rst_req_n, 1'b0, "R9 rst_req_n at reset");
    repeat (3) ref_tick();

    // R2: release timing of the PLL reset
    glob_rst_n = 1'b1;
    ref_tick(); check(pll_rst, 1'b1, "R2 after edge 1");
    ref_tick(); check(pll_rst, 1'b0, "R2 after edge 2");

    // R7: no lock keeps PHY in reset
    repeat (10) phy_tick();
    check(phy_rst, 1'b1, "R7 phy_rst without lock");
    check(reconf_rst, 1'b0, "R10 no pulse from global release");

    // R6: lock qualification
    phy_tick(); pll_locked = 1'b1;
    #0.5 check(rst_req_n, 1'b1, "R9 rst_req_n after lock");
    for (int k = 1; k <= 4; k++) begin
      phy_tick(); check(phy_rst, 1'b1, "R6 still held");
    end
    phy_tick(); check(phy_rst, 1'b0, "R6 released at edge 5");

    // R8: lock loss while running
    repeat (3) phy_tick();
    #2 pll_locked = 1'b0;
    #0.5 check(phy_rst, 1'b1, "R8 immediate reassert");
    check(rst_req_n, 1'b0, "R9 rst_req_n on lock loss");
    pll_locked = 1'b1;
    repeat (10) phy_tick();
    check(phy_rst, 1'b0, "R6 released after relock");

    // R3/R4: soft reset falling edge
    ref_tick(); soft_rst_n = 1'b0;
    #0.5 check(phy_rst, 1'b1, "R3 immediate phy_rst");
    check(pll_rst, 1'b0, "R3 pll_rst spared");
    ref_tick(); check(reconf_rst, 1'b0, "R4 low after edge 1");
    ref_tick(); check(reconf_rst, 1'b0, "R4 low after edge 2");
    for (int k = 3; k <= 6; k++) begin
      ref_tick(); check(reconf_rst, 1'b1, "R4 pulse high");
    end
    ref_tick(); check(reconf_rst, 1'b0, "R4 low after 4 cycles");

    // R5: held low and release do not retrigger
    for (int k = 0; k < 20; k++) begin
      ref_tick();
      check(reconf_rst, 1'b0, "R5 held low no pulse");
      check(pll_rst, 1'b0, "R3 pll_rst spared while held");
    end
    soft_rst_n = 1'b1;
    for (int k = 0; k < 10; k++) begin
      ref_tick(); check(reconf_rst, 1'b0, "R5 rising edge no pulse");
    end

    // R10: global released while soft is already low
    glob_rst_n = 1'b0; soft_rst_n = 1'b0;
    repeat (3) ref_tick();
    glob_rst_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      ref_tick();
      if (k >= 2) check(reconf_rst, 1'b0, "R10 no pulse with soft low");
    end
    check(pll_rst, 1'b0, "R2 PLL released with soft low");

    // Table walk: immediate effects of each reset combination
    foreach (VEC[i]) begin
      release_all();
      {glob_rst_n, soft_rst_n, pll_locked} = VEC[i];
      #1;
      check(phy_rst, 1'b1, "R1 R3 R8 phy_rst in table");
      check(rst_req_n, VEC[i][0], "R9 rst_req_n in table");
      check(pll_rst, ~VEC[i][2], "R1 R3 pll_rst in table");
      if (!VEC[i][2]) check(reconf_rst, 1'b1, "R1 reconf_rst in table");
    end
    release_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule